// File: doc/BRIEF.md
# Serial Asynchronous Receiver with Line Status

This block receives characters from an asynchronous serial line. The line is sampled on a 16x oversampling clock enable, and each received character is built up in a shift register. The block then stores the character in a 16-entry receive FIFO, together with three error tags that belong to that character: parity, framing and break. Word length (5 to 8 bits), parity (off, even or odd) and the number of stop bits (1 or 2) are set through static configuration inputs.

A host reads the block through two read strobes. Reading the data register returns the character at the head of the FIFO and removes it. Reading the status register returns a 5-bit line status word, and the sticky error bits clear at the end of that read cycle. The error tags of a character reach the status word only when that character becomes the head of the FIFO. Overrun is different: it is flagged as soon as a character is lost because the FIFO was full.

There are two recovery behaviours. A zero stop bit is taken as the start bit of the next character. A line held low through a whole character is reported once as a break, and the receiver then waits for the line to return high.

Top module: `serial_rx_status`

## Requirements
- R1: After reset `statusOut` is 0, so the FIFO is empty and no error bits are set. Bit assignment of `statusOut`: bit0 data available, bit1 overrun, bit2 parity error, bit3 framing error, bit4 break.
- R2: A frame is one start bit (0), then the data bits LSB first, then an optional parity bit, then one stop bit (or two when `cfgTwoStop`=1). `cfgWordLen` codes 0..3 select 5..8 data bits. The character appears right-aligned on `dataOut`, with the unused upper bits at 0.
- R3: `statusOut` bit0 is 1 exactly while the FIFO holds at least one unread character.
- R4: `dataOut` shows the character at the FIFO head. A cycle with `rdData`=1 removes that character. `rdData` while the FIFO is empty has no effect.
- R5: If a character completes while the FIFO holds 16 entries, the character is dropped and the FIFO contents stay unchanged. `statusOut` bit1 is set on the next cycle.
- R6: With parity enabled, the character is tagged with a parity error when the received parity bit differs from the expected value. Even parity (`cfgParityOdd`=0) expects an even number of ones over data and parity; odd parity expects an odd number.
- R7: A 0 in the first stop bit tags the character with a framing error. That zero stop bit is taken as the start bit of the next character, and reception continues from there.
- R8: If the data bits, the parity bit (when enabled) and the first stop bit are all 0, exactly one all-zero character is stored with the break and framing tags set. The receiver then ignores the line until it returns to 1.
- R9: A low on the line that is no longer low at the middle of the start bit (8 oversample ticks in) is rejected, and no character is stored.
- R10: Status bits 2..4 take the tags of a character when it becomes the FIFO head. They stay set until a status read, even if that character has already been removed.
- R11: A cycle with `rdStatus`=1 clears status bits 1..4 at its end. A flag that is set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxLine | input | 1 | Serial receive line, idle high |
| cfgWordLen | input | 2 | Data bits minus 5 |
| cfgParityEn | input | 1 | Parity bit present |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| cfgTwoStop | input | 1 | Two stop bits |
| rdData | input | 1 | Data register read strobe (pops the head) |
| rdStatus | input | 1 | Status register read strobe (clears the sticky bits) |
| dataOut | output | 8 | Character at the FIFO head |
| statusOut | output | 5 | Line status word |

## Verification
The assertions assume that the configuration inputs stay still while a character is in flight, and that the read strobes are single-cycle pulses issued by a host that reads synchronously. The bench changes configuration only while the line is idle and after the FIFO has been drained. It issues reads as one-cycle pulses away from the clock edge, and holds `tick16` high so that every bit lasts exactly 16 clocks. Random data, word lengths, parity modes and parity faults are mixed with directed sequences for overrun, framing resynchronisation, break, glitches and the sticky behaviour of status bits after a pop.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int CHAR_W = 8;
  localparam int TAG_W  = 3;
  localparam int ENTRY_W = CHAR_W + TAG_W;

  // per-character error tags
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxTag_t;

  typedef struct packed {
    rxTag_t             tag;
    logic [CHAR_W-1:0]  data;
  } rxEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearChar;
    logic shiftBit;
    logic takeParity;
    logic push;
    logic tagFrame;
    logic tagBreak;
  } rxStrobe_t;

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxLine,
  input  logic [1:0] cfgWordLen,
  input  logic       cfgParityEn,
  input  logic       cfgTwoStop,
  input  logic       charZero,
  output logic       rxBit,
  output rxStrobe_t  stb
);

  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OS_RATE - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PARITY, S_STOP1, S_STOP2, S_MARK
  } rxState_t;

  rxState_t state, stateNx;
  logic [CNT_W-1:0] tickCnt, tickCntNx;
  logic [2:0] bitCnt, bitCntNx;
  logic [SYNC_STAGES-1:0] syncQ;
  logic rxS;
  logic atFull;
  logic [2:0] lastBit;

  // input synchroniser, idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end

  assign rxS     = syncQ[SYNC_STAGES-1];
  assign rxBit   = rxS;
  assign atFull  = (tickCnt == FULL_CNT);
  assign lastBit = {1'b1, cfgWordLen};

  always_comb begin
    stateNx   = state;
    tickCntNx = tickCnt;
    bitCntNx  = bitCnt;
    stb       = '0;
    if (tick) begin
      case (state)
        S_IDLE: begin
          if (!rxS) begin
            stateNx   = S_START;
            tickCntNx = '0;
          end
        end
        S_START: begin
          if (tickCnt == MID_CNT) begin
            tickCntNx = '0;
            if (!rxS) begin
              stateNx       = S_DATA;
              bitCntNx      = '0;
              stb.clearChar = 1'b1;
            end else begin
              stateNx = S_IDLE;
            end
          end else begin
            tickCntNx = tickCnt + 1'b1;
          end
        end
        S_DATA: begin
          if (atFull) begin
            tickCntNx    = '0;
            stb.shiftBit = 1'b1;
            if (bitCnt == lastBit) begin
              bitCntNx = '0;
              stateNx  = cfgParityEn ? S_PARITY : S_STOP1;
            end else begin
              bitCntNx = bitCnt + 1'b1;
            end
          end else begin
            tickCntNx = tickCnt + 1'b1;
          end
        end
        S_PARITY: begin
          if (atFull) begin
            tickCntNx      = '0;
            stb.takeParity = 1'b1;
            stateNx        = S_STOP1;
          end else begin
            tickCntNx = tickCnt + 1'b1;
          end
        end
        S_STOP1: begin
          if (atFull) begin
            tickCntNx = '0;
            if (!rxS && charZero) begin
              stb.push     = 1'b1;
              stb.tagFrame = 1'b1;
              stb.tagBreak = 1'b1;
              stateNx      = S_MARK;
            end else if (!rxS) begin
              // bad stop bit doubles as the next start bit
              stb.push      = 1'b1;
              stb.tagFrame  = 1'b1;
              stb.clearChar = 1'b1;
              bitCntNx      = '0;
              stateNx       = S_DATA;
            end else if (cfgTwoStop) begin
              stateNx = S_STOP2;
            end else begin
              stb.push = 1'b1;
              stateNx  = S_IDLE;
            end
          end else begin
            tickCntNx = tickCnt + 1'b1;
          end
        end
        S_STOP2: begin
          if (atFull) begin
            tickCntNx    = '0;
            stb.push     = 1'b1;
            stb.tagFrame = !rxS;
            if (!rxS) begin
              stb.clearChar = 1'b1;
              bitCntNx      = '0;
              stateNx       = S_DATA;
            end else begin
              stateNx = S_IDLE;
            end
          end else begin
            tickCntNx = tickCnt + 1'b1;
          end
        end
        S_MARK: begin
          if (rxS) stateNx = S_IDLE;
        end
        default: stateNx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      state   <= stateNx;
      tickCnt <= tickCntNx;
      bitCnt  <= bitCntNx;
    end
  end

  // a start low that is gone by mid-bit returns to idle
  assert_glitch_reject_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_START && tick && tickCnt == MID_CNT && rxS) |=> (state == S_IDLE));

  // break leaves the receiver parked until the line is high
  assert_break_parks_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.tagBreak |=> (state == S_MARK));

  assert_mark_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MARK) |-> !stb.push);

  assert_one_action_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftBit, stb.takeParity, stb.push}));

endmodule

// File: rtl/serial_rx_dp.sv
module serial_rx_dp
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic              rxBit,
  input  logic [1:0]        cfgWordLen,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              rdData,
  input  logic              rdStatus,
  output logic              charZero,
  output logic [CHAR_W-1:0] dataOut,
  output logic [4:0]        statusOut
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CHAR_W-1:0] shiftReg;
  logic              parBit;
  logic [CHAR_W-1:0] alignData;
  logic [2:0]        shiftAmt;
  logic              parFail;
  rxEntry_t          pushEntry, headNext;
  rxEntry_t          fifoMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, rdPtrInc;
  logic [CNT_W-1:0]  count;
  logic              full, pushAcc, popAcc, newHead;
  logic              ovrS, parS, frmS, brkS;

  // character assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (stb.clearChar) begin
        shiftReg <= '0;
        parBit   <= 1'b0;
      end else begin
        if (stb.shiftBit)   shiftReg <= {rxBit, shiftReg[CHAR_W-1:1]};
        if (stb.takeParity) parBit   <= rxBit;
      end
    end
  end

  assign shiftAmt  = 3'd3 - {1'b0, cfgWordLen};
  assign alignData = shiftReg >> shiftAmt;
  assign charZero  = (shiftReg == '0) && (!cfgParityEn || !parBit);
  assign parFail   = cfgParityEn && !stb.tagBreak && (parBit != (^alignData ^ cfgParityOdd));

  always_comb begin
    pushEntry.data    = alignData;
    pushEntry.tag.brk = stb.tagBreak;
    pushEntry.tag.frm = stb.tagFrame;
    pushEntry.tag.par = parFail;
  end

  // receive FIFO
  assign full     = (count == FULL_CNT);
  assign pushAcc  = stb.push && !full;
  assign popAcc   = rdData && (count != '0);
  assign rdPtrInc = (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;

  always_ff @(posedge clk) begin
    if (pushAcc) fifoMem[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushAcc) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popAcc)  rdPtr <= rdPtrInc;
      case ({pushAcc, popAcc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // which entry becomes the head this cycle
  always_comb begin
    newHead  = 1'b0;
    headNext = pushEntry;
    if (count == '0) begin
      newHead = pushAcc;
    end else if (popAcc) begin
      if (count == CNT_W'(1)) begin
        newHead = pushAcc;
      end else begin
        newHead  = 1'b1;
        headNext = fifoMem[rdPtrInc];
      end
    end
  end

  // sticky status bits: a set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrS <= 1'b0;
      parS <= 1'b0;
      frmS <= 1'b0;
      brkS <= 1'b0;
    end else begin
      ovrS <= (ovrS && !rdStatus) || (stb.push && full);
      parS <= (parS && !rdStatus) || (newHead && headNext.tag.par);
      frmS <= (frmS && !rdStatus) || (newHead && headNext.tag.frm);
      brkS <= (brkS && !rdStatus) || (newHead && headNext.tag.brk);
    end
  end

  assign dataOut   = (count != '0) ? fifoMem[rdPtr].data : '0;
  assign statusOut = {brkS, frmS, parS, ovrS, (count != '0)};

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  assert_overrun_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && full) |=> statusOut[1]);

  assert_overrun_keeps_fifo_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && full && !rdData) |=> (count == $past(count)) && $stable(wrPtr));

  assert_ready_drops_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && count == CNT_W'(1) && !stb.push) |=> !statusOut[0]);

  assert_status_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !stb.push && !newHead) |=> (statusOut[4:1] == 4'b0));

  assert_empty_pop_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && count == '0 && !stb.push) |=> (count == '0) && $stable(rdPtr));

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxLine,
  input  logic [1:0] cfgWordLen,
  input  logic       cfgParityEn,
  input  logic       cfgParityOdd,
  input  logic       cfgTwoStop,
  input  logic       rdData,
  input  logic       rdStatus,
  output logic [7:0] dataOut,
  output logic [4:0] statusOut
);

  rxStrobe_t stb;
  logic      rxBit;
  logic      charZero;

  serial_rx_ctrl #(
    .OS_RATE(OS_RATE),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .tick(tick16),
    .rxLine(rxLine),
    .cfgWordLen(cfgWordLen),
    .cfgParityEn(cfgParityEn),
    .cfgTwoStop(cfgTwoStop),
    .charZero(charZero),
    .rxBit(rxBit),
    .stb(stb)
  );

  serial_rx_dp #(
    .DEPTH(FIFO_DEPTH)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .rxBit(rxBit),
    .cfgWordLen(cfgWordLen),
    .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd),
    .rdData(rdData),
    .rdStatus(rdStatus),
    .charZero(charZero),
    .dataOut(dataOut),
    .statusOut(statusOut)
  );

endmodule

// File: tb/sim_serial_rx_status.sv
`timescale 1ns/1ps
module sim_serial_rx_status;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b1;
  logic       rxLine = 1'b1;
  logic [1:0] cfgWordLen = 2'd3;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       cfgTwoStop = 1'b0;
  logic       rdData = 1'b0;
  logic       rdStatus = 1'b0;
  logic [7:0] dataOut;
  logic [4:0] statusOut;

  int checks = 0;
  int fails = 0;
  logic [10:0] expQ[$];

  always #10 clk = ~clk;

  serial_rx_status u0 (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .cfgWordLen(cfgWordLen), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .rdData(rdData), .rdStatus(rdStatus),
    .dataOut(dataOut), .statusOut(statusOut)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitTime(input logic v);
    rxLine = v;
    repeat (16) @(negedge clk);
  endtask

  function automatic logic [7:0] maskData(input logic [7:0] d, input int len);
    return d & 8'((1 << len) - 1);
  endfunction

  function automatic logic [10:0] expEntry(input logic [7:0] d, input int len, input logic parErr);
    return {1'b0, 1'b0, parErr, maskData(d, len)};
  endfunction

  task automatic sendFrame(input logic [7:0] d, input logic flipPar, input logic badStop);
    int len;
    logic p;
    len = 5 + int'(cfgWordLen);
    p = (^maskData(d, len)) ^ cfgParityOdd ^ flipPar;
    bitTime(1'b0);
    for (int i = 0; i < len; i++) bitTime(d[i]);
    if (cfgParityEn) bitTime(p);
    bitTime(!badStop);
    if (cfgTwoStop) bitTime(1'b1);
    rxLine = 1'b1;
  endtask

  task automatic pulseStatus();
    rdStatus = 1'b1;
    @(negedge clk);
    rdStatus = 1'b0;
  endtask

  task automatic pulseData();
    rdData = 1'b1;
    @(negedge clk);
    rdData = 1'b0;
  endtask

  task automatic drain(input logic ovrFirst);
    logic [10:0] e;
    logic ovr;
    string req;
    ovr = ovrFirst;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      @(negedge clk);
      if (e[10]) req = "R8";
      else if (e[9]) req = "R7";
      else if (e[8]) req = "R6";
      else req = "R3";
      check(32'(statusOut), 32'({e[10:8], ovr, 1'b1}), req);
      pulseStatus();
      ovr = 1'b0;
      check(32'(dataOut), 32'(e[7:0]), "R4 data R2");
      pulseData();
    end
    check(32'(statusOut), 32'h0, "R3 empty R11");
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL timeout R3 actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic fp;
    int n;
    logic [31:0] seed;
    seed = 32'h5eed_0023;
    void'($urandom(seed));

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(32'(statusOut), 32'h0, "R1 reset");

    // R2 R6: random frames, configs and parity faults
    for (int b = 0; b < 12; b++) begin
      cfgWordLen   = 2'($urandom_range(0, 3));
      cfgParityEn  = 1'($urandom_range(0, 1));
      cfgParityOdd = 1'($urandom_range(0, 1));
      cfgTwoStop   = 1'($urandom_range(0, 1));
      repeat (4) @(negedge clk);
      n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) begin
        d  = 8'($urandom);
        fp = cfgParityEn && ($urandom_range(0, 3) == 0);
        sendFrame(d, fp, 1'b0);
        expQ.push_back(expEntry(d, 5 + int'(cfgWordLen), fp));
        bitTime(1'b1);
      end
      bitTime(1'b1);
      drain(1'b0);
    end

    // R9: glitch rejected; R4: read on empty ignored
    cfgWordLen = 2'd3; cfgParityEn = 1'b0; cfgParityOdd = 1'b0; cfgTwoStop = 1'b0;
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    bitTime(1'b1); bitTime(1'b1);
    check(32'(statusOut), 32'h0, "R9 glitch");
    pulseData();
    sendFrame(8'hA5, 1'b0, 1'b0);
    bitTime(1'b1);
    expQ.push_back(expEntry(8'hA5, 8, 1'b0));
    drain(1'b0);

    // R5: overrun drops the 17th character
    for (int k = 0; k < 17; k++) begin
      d = 8'(k * 13 + 1);
      sendFrame(d, 1'b0, 1'b0);
      if (k < 16) expQ.push_back(expEntry(d, 8, 1'b0));
    end
    @(negedge clk);
    check(32'(statusOut[1:0]), 32'h3, "R5 overrun flag");
    drain(1'b1);

    // R7: bad stop bit, then the stop bit acts as a start bit
    sendFrame(8'h5A, 1'b0, 1'b1);
    for (int k = 0; k < 12; k++) bitTime(1'b1);
    expQ.push_back({3'b010, 8'h5A});
    expQ.push_back(expEntry(8'hFF, 8, 1'b0));
    drain(1'b0);

    // R8: long low gives one break character, then idle until high
    cfgParityEn = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 30; k++) bitTime(1'b0);
    check(32'(statusOut), 32'h19, "R8 break status");
    bitTime(1'b1); bitTime(1'b1);
    sendFrame(8'h33, 1'b0, 1'b0);
    bitTime(1'b1);
    expQ.push_back({3'b110, 8'h00});
    expQ.push_back(expEntry(8'h33, 8, 1'b0));
    drain(1'b0);

    // R10: head tags stay sticky after pop; R11 clears them
    sendFrame(8'h3C, 1'b1, 1'b0);
    bitTime(1'b1);
    sendFrame(8'h3C, 1'b0, 1'b0);
    bitTime(1'b1);
    check(32'(statusOut), 32'h05, "R10 head parity tag");
    pulseData();
    check(32'(statusOut), 32'h05, "R10 sticky after pop");
    pulseStatus();
    check(32'(statusOut), 32'h01, "R11 cleared by read");
    check(32'(dataOut), 32'h3C, "R4 second char");
    pulseData();
    check(32'(statusOut), 32'h0, "R3 empty");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule